// File: doc/BRIEF.md
# Trail Trace Message Generator

This block produces a repeating sixteen-byte path identification message and hands it out one byte per frame. A header byte leads each message and fifteen character bytes follow it. The host loads the fifteen characters through a simple write port. The block builds the header byte itself: the top bit is set and the low seven bits hold a CRC-7 check value.

The CRC-7 in a header covers the complete message that came before it, header included, and never the message it heads. Only the header byte may have its top bit set, which lets a far-end receiver find where each message starts. Host writes first land in a staging copy and are moved into the live copy only at a message boundary. Each message on the line therefore matches the CRC that is later sent for it. A character write with the top bit set is stored with that bit cleared, and it raises a sticky error flag.

Top module: `trace_msg_gen`

## Requirements
- R1: After reset `byte_idx` is 0. Each single-cycle `frame_stb` pulse advances it by one on the next clock, it wraps from 15 to 0, and it holds while `frame_stb` is low.
- R2: When `byte_idx` is 1 to 15, `tx_byte` equals the live character stored for that index, and its bit 7 is always 0.
- R3: When `byte_idx` is 0, `tx_byte` is the header: bit 7 is 1 and bits 6..0 are the held CRC-7.
- R4: The CRC-7 uses the generator x^7 + x^3 + 1 (feedback mask 0x09). Data bits are taken MSB first. The CRC register starts at zero for each message and takes in all sixteen bytes as they are sent, header included.
- R5: The held CRC is loaded only on the strobe that sends byte 15, so a header carries the CRC of the previous message. After reset the held CRC is 0, so the first header is 0x80.
- R6: Writes to addresses 1 to 15 go to a staging copy. The staging copy becomes live on the strobe that sends byte 15, so a write made partway through a message leaves the rest of that message unchanged.
- R7: A write to addresses 1 to 15 with bit 7 of `wr_data` set is stored with bit 7 cleared and sets `char_err`. The flag stays set until it is cleared.
- R8: A pulse on `err_clr` clears `char_err` on the next clock. If a bad write comes in the same cycle, setting the flag takes priority.
- R9: A write to address 0 changes no stored byte and does not set `char_err`.
- R10: After reset every character byte is 0x00 and `char_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse: the current byte has been sent |
| wr_en | input | 1 | Host write enable |
| wr_addr | input | 4 | Host write byte address (0 to 15) |
| wr_data | input | 8 | Host write character |
| err_clr | input | 1 | Clears the sticky character error flag |
| tx_byte | output | 8 | Message byte for the current index |
| byte_idx | output | 4 | Current byte index inside the message |
| char_err | output | 1 | Sticky flag: a character with bit 7 set was written |

## Verification
The bench works out each CRC-7 itself and checks that a header carries the previous message's value. A design that used the current message, or left the header out of the CRC, would send wrong header bytes from the second message on. A write made partway through a message is checked to stay hidden until the next message; a design that wrote straight to the live copy would change bytes mid-message and break the CRC match. Bad characters, the set-over-clear priority, writes to address 0 and the first 0x80 header are each checked at the ports. A design that dropped the masking, the priority or the address-0 guard would show a top bit set past the header, a lost flag or a damaged header.

// File: rtl/trace_pkg.sv
package trace_pkg;
   localparam int TRC_BYTE_W = 8;
   localparam int TRC_CRC_W  = 7;
   localparam logic [TRC_CRC_W-1:0] TRC_POLY = 7'h09;
   typedef logic [TRC_BYTE_W-1:0] trc_byte_t;
endpackage

// File: rtl/trace_seq.sv
module trace_seq #(
   parameter int MSG_LEN = 16,
   localparam int IDX_W = $clog2(MSG_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   output logic [IDX_W-1:0] idx,
   output logic             wrap
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(MSG_LEN - 1);

   assign wrap = stb && (idx == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)     idx <= '0;
      else if (wrap)  idx <= '0;
      else if (stb)   idx <= idx + 1'b1;
   end

   a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && idx == LAST) |=> (idx == '0));
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(idx));
endmodule

// File: rtl/trace_crc.sv
module trace_crc
   import trace_pkg::*;
#(
   parameter int BYTE_W = TRC_BYTE_W,
   parameter int CRC_W  = TRC_CRC_W,
   parameter logic [CRC_W-1:0] POLY = TRC_POLY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              last,
   input  logic [BYTE_W-1:0] data,
   output logic [CRC_W-1:0]  crc_held
);
   logic [CRC_W-1:0] acc_q;
   logic [CRC_W-1:0] acc_nxt;

   function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                 input logic [BYTE_W-1:0] d);
      logic [CRC_W-1:0] r;
      logic fb;
      r = c;
      for (int b = BYTE_W - 1; b >= 0; b--) begin
         fb = r[CRC_W-1] ^ d[b];
         r  = {r[CRC_W-2:0], 1'b0};
         if (fb) r = r ^ POLY;
      end
      return r;
   endfunction

   assign acc_nxt = crc_byte(acc_q, data);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q    <= '0;
         crc_held <= '0;
      end else if (step) begin
         if (last) begin
            crc_held <= acc_nxt;
            acc_q    <= '0;
         end else begin
            acc_q <= acc_nxt;
         end
      end
   end

   a_r5_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(step && last) |=> $stable(crc_held));
   a_r4_acc_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last) |=> (acc_q == '0));
endmodule

// File: rtl/trace_regs.sv
module trace_regs
   import trace_pkg::*;
#(
   parameter int MSG_LEN = 16,
   parameter int BYTE_W  = TRC_BYTE_W,
   localparam int IDX_W = $clog2(MSG_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              err_clr,
   input  logic              commit,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [BYTE_W-1:0] rd_char,
   output logic              char_err
);
   logic [BYTE_W-1:0] stg_q [MSG_LEN];
   logic [BYTE_W-1:0] act_q [MSG_LEN];
   logic              bad_wr;

   assign bad_wr  = wr_en && (wr_addr != '0) && wr_data[BYTE_W-1];
   assign rd_char = act_q[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < MSG_LEN; k++) begin
            stg_q[k] <= '0;
            act_q[k] <= '0;
         end
      end else begin
         for (int k = 0; k < MSG_LEN; k++) begin
            if (k != 0 && wr_en && wr_addr == IDX_W'(k))
               stg_q[k] <= {1'b0, wr_data[BYTE_W-2:0]};
            if (commit)
               act_q[k] <= stg_q[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       char_err <= 1'b0;
      else if (bad_wr)  char_err <= 1'b1;
      else if (err_clr) char_err <= 1'b0;
   end

   generate
      for (genvar g = 0; g < MSG_LEN; g++) begin : g_chk
         a_r6_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
            !commit |=> $stable(act_q[g]));
      end
   endgenerate

   a_r2_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> !rd_char[BYTE_W-1]);
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (char_err && !err_clr) |=> char_err);
   a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> char_err);
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !bad_wr) |=> !char_err);
endmodule

// File: rtl/trace_msg_gen.sv
module trace_msg_gen
   import trace_pkg::*;
#(
   parameter int MSG_LEN = 16,
   parameter int BYTE_W  = TRC_BYTE_W,
   parameter int CRC_W   = TRC_CRC_W,
   parameter logic [CRC_W-1:0] POLY = TRC_POLY,
   localparam int IDX_W = $clog2(MSG_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              err_clr,
   output logic [BYTE_W-1:0] tx_byte,
   output logic [IDX_W-1:0]  byte_idx,
   output logic              char_err
);
   generate
      if (MSG_LEN < 2 || (1 << IDX_W) != MSG_LEN) begin : g_bad_len
         $error("MSG_LEN must be a power of two of at least 2");
      end
      if (CRC_W + 1 != BYTE_W) begin : g_bad_w
         $error("CRC_W must be one less than BYTE_W");
      end
   endgenerate

   logic             wrap;
   logic [CRC_W-1:0] crc_held;
   logic [BYTE_W-1:0] rd_char;

   trace_seq #(.MSG_LEN(MSG_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .stb(frame_stb), .idx(byte_idx), .wrap(wrap));

   trace_regs #(.MSG_LEN(MSG_LEN), .BYTE_W(BYTE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .err_clr(err_clr), .commit(wrap),
      .rd_idx(byte_idx), .rd_char(rd_char), .char_err(char_err));

   trace_crc #(.BYTE_W(BYTE_W), .CRC_W(CRC_W), .POLY(POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .step(frame_stb), .last(wrap),
      .data(tx_byte), .crc_held(crc_held));

   assign tx_byte = (byte_idx == '0) ? {1'b1, crc_held} : rd_char;

   a_r3_header_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_idx == '0) |-> tx_byte[BYTE_W-1]);
   a_r2_body_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_idx != '0) |-> !tx_byte[BYTE_W-1]);
endmodule

// File: tb/trace_msg_gen_bench.sv
module trace_msg_gen_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_stb = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       err_clr = 1'b0;
   logic [7:0] tx_byte;
   logic [3:0] byte_idx;
   logic       char_err;

   int n_checks = 0;
   int n_errs = 0;
   bit done = 0;

   logic [7:0] cur_msg [16];
   logic [7:0] nxt_msg [16];
   logic [6:0] exp_crc = '0;

   // {addr[3:0], data[7:0], stored[7:0], exp_err}
   localparam logic [20:0] VEC [8] = '{
      {4'd1,  8'h49, 8'h49, 1'b0},
      {4'd2,  8'h54, 8'h54, 1'b0},
      {4'd3,  8'hC1, 8'h41, 1'b1},
      {4'd4,  8'h30, 8'h30, 1'b0},
      {4'd5,  8'hFF, 8'h7F, 1'b1},
      {4'd9,  8'h37, 8'h37, 1'b0},
      {4'd15, 8'h5A, 8'h5A, 1'b0},
      {4'd0,  8'h55, 8'h00, 1'b0}
   };

   trace_msg_gen u_trace_msg_gen (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .err_clr(err_clr),
      .tx_byte(tx_byte), .byte_idx(byte_idx), .char_err(char_err));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [6:0] ref_crc(input logic [6:0] c, input logic [7:0] d);
      logic [6:0] r = c;
      for (int b = 7; b >= 0; b--) begin
         if (r[6] ^ d[b]) r = {r[5:0], 1'b0} ^ 7'h09;
         else             r = {r[5:0], 1'b0};
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   endtask

   task automatic strobe();
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
   endtask

   task automatic host_wr(input logic [3:0] a, input logic [7:0] d, input logic clr);
      wr_en = 1'b1; wr_addr = a; wr_data = d; err_clr = clr;
      @(negedge clk);
      wr_en = 1'b0; err_clr = 1'b0;
      if (a != 0) nxt_msg[a] = {1'b0, d[6:0]};
   endtask

   // send one whole message, checking every byte; optional write partway through
   task automatic send_msg(input logic [3:0] mid_addr, input logic [7:0] mid_data);
      logic [6:0] run = '0;
      logic [7:0] e;
      for (int i = 0; i < 16; i++) begin
         e = (i == 0) ? {1'b1, exp_crc} : cur_msg[i];
         check("R1 index", byte_idx, i);
         if (i == 0) check("R3/R5 header", tx_byte, e);
         else        check("R2/R6 char", tx_byte, e);
         run = ref_crc(run, e);
         if (i == 5 && mid_addr != 0) host_wr(mid_addr, mid_data, 1'b0);
         strobe();
      end
      exp_crc = run;                       // R4: CRC of message just sent
      for (int k = 0; k < 16; k++) cur_msg[k] = nxt_msg[k];
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      for (int k = 0; k < 16; k++) begin cur_msg[k] = '0; nxt_msg[k] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 / R5 reset state
      check("R1 reset idx", byte_idx, 0);
      check("R5 first header", tx_byte, 8'h80);
      check("R10 reset err", char_err, 0);

      // R1 hold without strobe
      strobe(); strobe();
      repeat (5) @(negedge clk);
      check("R1 hold", byte_idx, 2);
      check("R10 reset char", tx_byte, 8'h00);
      // go back to start of message (bytes so far are zero)
      for (int i = 2; i < 16; i++) strobe();
      exp_crc = '0;
      for (int i = 0; i < 16; i++) exp_crc = ref_crc(exp_crc, (i == 0) ? 8'h80 : 8'h00);

      // message 2: write byte 7 partway through (R6), must not show yet
      send_msg(4'd7, 8'h41);
      // message 3 carries byte 7, walk vector table during it
      for (int v = 0; v < 8; v++) begin
         host_wr(VEC[v][20:17], VEC[v][16:9], 1'b0);
         check(VEC[v][20:17] == 0 ? "R9 no err" : "R7 err flag", char_err, VEC[v][0]);
         if (VEC[v][20:17] != 0) check("R7 stored mask", nxt_msg[VEC[v][20:17]], VEC[v][8:1]);
         err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
         check("R8 clear", char_err, 0);
      end
      // R8: set wins over clear
      host_wr(4'd12, 8'hB3, 1'b1);
      check("R8 set priority", char_err, 1);
      err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
      check("R8 clear after", char_err, 0);
      // finish rest of current message (vector writes happened at idx 0)
      check("R1 idx before finish", byte_idx, 0);
      send_msg(4'd0, 8'h00);
      // message with table contents; R9 header intact
      send_msg(4'd0, 8'h00);
      send_msg(4'd0, 8'h00);
      check("R1 wrap idx", byte_idx, 0);
      check("R3 final header", tx_byte, {1'b1, exp_crc});
      finish_run();
   end
endmodule